// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Clock Select

This block moves bytes over a three-wire synchronous serial link: a data-out line, a data-in line and a bit clock. The bit clock runs at the bit rate with no oversampling. It comes from one of two sources. It can be an external clock that arrives on the clock pin. It can also be a clock that the block builds from an internal baud tick and drives out on that same pin. Outgoing bits change on the rising edge of the bit clock. Incoming bits are sampled on its falling edge.

Each byte is eight bits, sent least significant bit first, with no start or stop bits. A transmit holding register lets software queue the next byte while the current one is shifting out, and a receive buffer holds the last complete byte. All logic runs on the system clock. The external clock and data-in are brought into that domain through a chain of synchroniser flops, and their edges are detected there, so no clock is ever gated.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset: tx_empty=1, rx_full=0, sdo=1, sclk_out=1 and sclk_oe=0.
- R2: While sync_en=0, no bit is shifted in either direction and sclk_oe=0. Clock edges on ext_sclk_in leave rx_full unchanged, and the receive bit count restarts.
- R3: sclk_oe equals sync_en AND int_clk_sel. With int_clk_sel=1, the generated clock toggles on each baud_tick while a byte is shifting, so one bit takes two ticks and one byte gives exactly eight falling clock edges.
- R4: With int_clk_sel=1 and no byte shifting or pending, sclk_out stays high (idle high).
- R5: Transmit bits leave on sdo least significant bit first. Bit 0 appears when a byte enters the shifter, and each following bit appears after a rising bit-clock edge. sdo is 1 when nothing is shifting.
- R6: Receive samples the data-in line on each falling bit-clock edge, least significant bit first. After the eighth falling edge, rx_data holds the byte (bit 0 = first bit received) and rx_full=1.
- R7: A tx_load pulse while tx_empty=1 stores tx_data and drives tx_empty to 0. The byte moves into the shifter when the shifter is free, or on the rising edge that ends the current byte, which sets tx_empty back to 1. A tx_load while tx_empty=0 is ignored, and that byte is never sent.
- R8: An rx_read pulse clears rx_full. A new complete byte overwrites rx_data whether or not the old one was read. Queued bytes are sent back to back with no idle clock period between them.
- R9: In external clock mode, ext_sclk_in and sdi each pass through SYNC_STAGES flops before edges are detected, so a bit is taken from sdi as it stood when the external clock fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | Synchronous operation select; 1 = active |
| int_clk_sel | input | 1 | 1 = generate clock internally and drive pin; 0 = use external clock |
| baud_tick | input | 1 | Internal baud tick, one system-clock pulse per half bit |
| ext_sclk_in | input | 1 | External bit clock from the pin |
| sclk_out | output | 1 | Generated bit clock to the pin |
| sclk_oe | output | 1 | Clock pin output enable |
| tx_data | input | DATA_W | Byte to queue for transmit |
| tx_load | input | 1 | Write strobe for tx_data |
| tx_empty | output | 1 | Transmit holding register empty |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_data | output | DATA_W | Last received byte |
| rx_read | input | 1 | Read strobe clearing rx_full |
| rx_full | output | 1 | Receive buffer holds an unread byte |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2. With these values, a byte takes 16 baud ticks, and the synchroniser delay is short enough to fit well inside a 12-cycle external clock period. This makes the internal loopback, the back-to-back queue, the ignored third load and the receive overwrite all reachable within a few hundred cycles. In external mode, the bench drives the clock slowly enough that every bit can be observed on sdo and set up on sdi at a fixed cycle offset.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  // Shift one serial bit into the top of a right-shifting register (LSB first arrival).
  function automatic logic [7:0] ssx_shift_in(input logic [7:0] cur, input logic bit_in);
    return {bit_in, cur[7:1]};
  endfunction

  // Advance the transmit shifter: drop the bit just sent, fill with idle level.
  function automatic logic [7:0] ssx_shift_out(input logic [7:0] cur);
    return {1'b1, cur[7:1]};
  endfunction

  // True when a bit counter points at the final bit of a byte.
  function automatic logic ssx_is_last(input logic [3:0] cnt, input int unsigned width);
    return (int'(cnt) == int'(width) - 1);
  endfunction
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RESET_VAL;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/ssx_clkgen.sv
module ssx_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  assign rise_o = run_i && tick_i && !sclk_q;
  assign fall_o = run_i && tick_i &&  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sclk_q <= 1'b1;
    else if (!run_i) sclk_q <= 1'b1;
    else if (tick_i) sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;

  // R4: once the generator stops, the clock rests high
  a_r4_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && $past(!run_i)) |-> sclk_q);
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx import ssx_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic              empty_o,
  output logic              busy_o,
  output logic              sdo_o
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              finishing;
  logic              load_shift;
  logic              accept;

  assign finishing  = busy_q && rise_evt_i && ssx_is_last(cnt_q, DATA_W);
  assign load_shift = hold_full_q && (!busy_q || finishing);
  assign accept     = load_i && !hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_q      <= data_i;
      hold_full_q <= 1'b1;
    end else if (load_shift) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_shift) begin
      shreg_q <= hold_q;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && rise_evt_i) begin
      if (ssx_is_last(cnt_q, DATA_W)) begin
        busy_q  <= 1'b0;
        shreg_q <= '1;
      end else begin
        shreg_q <= ssx_shift_out(shreg_q);
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign empty_o = !hold_full_q;
  assign busy_o  = busy_q;
  assign sdo_o   = busy_q ? shreg_q[0] : 1'b1;

  // R5: the data line only moves after a rising edge or a fresh byte entering the shifter
  a_r5_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(rise_evt_i || load_shift));
  // R7: a load against a full holding register leaves the held byte untouched
  a_r7_full_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_q && load_i && !load_shift) |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx import ssx_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              fall_evt_i,
  input  logic              sdi_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done;
  logic [DATA_W-1:0] next_sh;

  assign next_sh = ssx_shift_in(shreg_q, sdi_i);
  assign done    = fall_evt_i && ssx_is_last(cnt_q, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
    end else if (fall_evt_i) begin
      shreg_q <= next_sh;
      cnt_q   <= done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (done && !clear_i) begin
      data_o <= next_sh;
      full_o <= 1'b1;
    end else if (read_i) begin
      full_o <= 1'b0;
    end
  end

  // R6: a completed byte can only appear right after a falling edge
  a_r6_full_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(fall_evt_i));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_en,
  input  logic              int_clk_sel,
  input  logic              baud_tick,
  input  logic              ext_sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_empty,
  output logic              sdo,
  input  logic              sdi,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_read,
  output logic              rx_full
);
  logic ext_lvl, ext_prev_q, sdi_lvl;
  logic ext_rise, ext_fall;
  logic gen_run, gen_rise, gen_fall;
  logic rise_evt, fall_evt;
  logic tx_busy, sdi_sel, use_int;

  ssx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_i(ext_sclk_in), .level_o(ext_lvl));
  ssx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .async_i(sdi), .level_o(sdi_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= ext_lvl;
  end

  assign use_int  = sync_en && int_clk_sel;
  assign ext_rise = sync_en && !int_clk_sel &&  ext_lvl && !ext_prev_q;
  assign ext_fall = sync_en && !int_clk_sel && !ext_lvl &&  ext_prev_q;
  assign gen_run  = use_int && tx_busy;

  ssx_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .run_i(gen_run), .tick_i(baud_tick),
    .sclk_o(sclk_out), .rise_o(gen_rise), .fall_o(gen_fall));

  assign rise_evt = use_int ? gen_rise : ext_rise;
  assign fall_evt = use_int ? gen_fall : ext_fall;
  assign sdi_sel  = use_int ? sdi : sdi_lvl;
  assign sclk_oe  = use_int;

  ssx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise_evt_i(rise_evt), .data_i(tx_data),
    .load_i(tx_load), .empty_o(tx_empty), .busy_o(tx_busy), .sdo_o(sdo));

  ssx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear_i(!sync_en), .fall_evt_i(fall_evt),
    .sdi_i(sdi_sel), .read_i(rx_read), .data_o(rx_data), .full_o(rx_full));

  // R9: the selected source never reports both edges in one cycle
  a_r9_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_evt, fall_evt}));
  // R2: with the mode bit clear no edge reaches the shifters
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |-> !(rise_evt || fall_evt));
  // R4: pin driven and nothing shifting for two cycles means the clock is high
  a_r4_idle_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !tx_busy && $past(!tx_busy) && $past(sclk_oe)) |-> sclk_out);
endmodule

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_en = 1'b0, int_clk_sel = 1'b0, baud_tick = 1'b0, ext_sclk_in = 1'b1;
  logic sclk_out, sclk_oe, tx_empty, sdo, rx_full;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_load = 1'b0, rx_read = 1'b0, sdi_drv = 1'b1, loop_en = 1'b0, tick_en = 1'b0;
  logic sdi;
  int errors = 0, checks = 0, nfall = 0, cyc = 0;

  assign sdi = loop_en ? sdo : sdi_drv;

  sync_serial_xcvr #(.DATA_W(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .int_clk_sel(int_clk_sel),
    .baud_tick(baud_tick), .ext_sclk_in(ext_sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
    .sdo(sdo), .sdi(sdi), .rx_data(rx_data), .rx_read(rx_read), .rx_full(rx_full));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    baud_tick <= tick_en && (cyc % 4 == 0);
  end

  always @(negedge sclk_out) nfall++;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] b);
    tx_data = b; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic read_rx();
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic wait_full();
    for (int i = 0; i < 400 && !rx_full; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] got;
    int f0;
    wait_cyc(3);
    // R1 reset state
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
    check(sdo == 1'b1, "R1 sdo", sdo, 1);
    check(sclk_out == 1'b1, "R1 sclk_out", sclk_out, 1);
    check(sclk_oe == 1'b0, "R1 sclk_oe", sclk_oe, 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // Internal clock, loopback: table of bytes
    sync_en = 1'b1; int_clk_sel = 1'b1; tick_en = 1'b1; loop_en = 1'b1;
    @(negedge clk);
    check(sclk_oe == 1'b1, "R3 sclk_oe internal", sclk_oe, 1);
    wait_cyc(10);
    check(sclk_out == 1'b1, "R4 idle high before send", sclk_out, 1);
    for (int v = 0; v < NVEC; v++) begin
      f0 = nfall;
      load_byte(VEC[v]);
      wait_full();
      check(rx_data == VEC[v], "R6 loopback data", rx_data, VEC[v]);
      check(rx_full == 1'b1, "R6 rx_full set", rx_full, 1);
      wait_cyc(12);
      check(nfall - f0 == 8, "R3 eight falls per byte", nfall - f0, 8);
      check(sclk_out == 1'b1, "R4 idle high after byte", sclk_out, 1);
      check(sdo == 1'b1, "R5 sdo idle", sdo, 1);
      check(tx_empty == 1'b1, "R7 tx_empty after send", tx_empty, 1);
      read_rx();
      check(rx_full == 1'b0, "R8 rx_read clears", rx_full, 0);
    end

    // Back-to-back queue, ignored third load, overwrite without read
    f0 = nfall;
    load_byte(8'h11);
    wait_cyc(3);
    load_byte(8'h22);
    check(tx_empty == 1'b0, "R7 holding full", tx_empty, 0);
    load_byte(8'h33);
    check(tx_empty == 1'b0, "R7 load while full ignored", tx_empty, 0);
    wait_full();
    got = rx_data;
    check(got == 8'h11, "R8 first queued byte", got, 8'h11);
    wait_cyc(4);
    check(sclk_out == 1'b0 || tx_empty == 1'b1, "R8 no idle between bytes", sclk_out, 0);
    wait_cyc(80);
    check(rx_data == 8'h22, "R8 overwrite by second byte", rx_data, 8'h22);
    check(rx_full == 1'b1, "R8 still full", rx_full, 1);
    check(nfall - f0 == 16, "R7 third byte never sent", nfall - f0, 16);
    wait_cyc(200);
    check(rx_data == 8'h22, "R7 no third byte", rx_data, 8'h22);
    read_rx();
    tick_en = 1'b0; loop_en = 1'b0;

    // External clock mode: transmit 0x96, receive 0x5B
    int_clk_sel = 1'b0;
    @(negedge clk);
    check(sclk_oe == 1'b0, "R3 sclk_oe external", sclk_oe, 0);
    load_byte(8'h96);
    wait_cyc(5);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      sdi_drv = (8'h5B >> i) & 1'b1;
      wait_cyc(4);
      got[i] = sdo;
      ext_sclk_in = 1'b0;
      wait_cyc(6);
      ext_sclk_in = 1'b1;
      wait_cyc(2);
    end
    wait_cyc(6);
    check(got == 8'h96, "R5 external sdo LSB first", got, 8'h96);
    check(rx_data == 8'h5B, "R9 external rx data", rx_data, 8'h5B);
    check(rx_full == 1'b1, "R6 external rx_full", rx_full, 1);
    check(sdo == 1'b1, "R5 sdo idle after external byte", sdo, 1);
    read_rx();

    // Mode bit clear: external edges have no effect
    sync_en = 1'b0;
    @(negedge clk);
    check(sclk_oe == 1'b0, "R2 sclk_oe off", sclk_oe, 0);
    for (int i = 0; i < 8; i++) begin
      sdi_drv = i[0];
      wait_cyc(4);
      ext_sclk_in = 1'b0;
      wait_cyc(6);
      ext_sclk_in = 1'b1;
      wait_cyc(2);
    end
    wait_cyc(6);
    check(rx_full == 1'b0, "R2 no receive when off", rx_full, 0);
    check(rx_data == 8'h5B, "R2 rx_data unchanged when off", rx_data, 8'h5B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule